// File: doc/BRIEF.md
# Four-Channel Transfer Controller Register File

This block is the host-side register file of a four-channel transfer controller. A host reaches it over an 8-bit I/O bus with a 4-bit offset. Each channel keeps a 16-bit start address and a 16-bit transfer count. Each of these has a base copy and a current copy. Because the bus is only one byte wide, every 16-bit value is loaded and read one byte at a time. A single byte-pointer flip-flop, shared by all channels, decides whether an access reaches the low byte or the high byte. Software puts the pointer into a known state by writing the clear-pointer offset.

The count register holds the wanted number of transfers minus one. The transfer engine sits outside this block. It reports each completed transfer on a one-cycle strobe that names the channel. On each strobe the register file increments the channel's current address and decrements its current count. When the count was already zero, the block raises a terminal-count pulse and latches a status flag. If the channel's mode has auto-initialize set, it also reloads the current copies from the base copies.

Beyond the per-channel registers, the block holds a mode byte per channel, a mask bit per channel, a command byte and a software request bit per channel. Several write strobes act on all channels at once: master clear, clear all masks and load all masks.

Top module: `xfer_ctl_regs`

## Requirements
- R1: After reset, all four mask bits are set, the byte pointer selects the low byte, and the command byte, mode bytes, software requests and terminal-count flags are zero.
- R2: Offset 2n reaches channel n's current address and offset 2n+1 reaches its current count. Every read or write at offsets 0x0 to 0x7 uses the byte named by the shared pointer (low byte first) and then toggles the pointer.
- R3: A write of any value to offset 0xC sets the pointer to the low byte.
- R4: A write at offset 2n or 2n+1 loads the selected byte into both the base and the current copy. A stored count of 0x0000 gives a terminal count on the first transfer. A stored 0xFFFF gives one on the 65536th transfer.
- R5: A write to offset 0xA uses bits 1:0 as the channel number. Bit 2 set masks that channel; bit 2 clear unmasks it.
- R6: A write to offset 0xB stores the whole byte as the mode of the channel named in bits 1:0. Channel n's mode appears on mode_o bits 8n+7:8n.
- R7: A strobe on xfer_stb for an unmasked channel adds one to its current address. If the current count is nonzero, the strobe subtracts one from it. If the count is zero, tc_o bit n pulses in that same cycle and the count wraps to 0xFFFF. A strobe for a masked channel changes nothing.
- R8: A write to offset 0xD clears the pointer, the terminal-count flags, the software requests and the command byte, and sets all four mask bits.
- R9: A write to offset 0xE clears all mask bits. A write to offset 0xF loads the four mask bits from data bits 3:0.
- R10: A read at offset 0x8 returns the terminal-count flags in bits 3:0 and (dreq_i OR software request) in bits 7:4. The read clears the terminal-count flags, but a terminal count that occurs in the same cycle stays set.
- R11: When mode bit 4 (auto-initialize) is set, a terminal count reloads the current address and count from their base copies.
- R12: A write to offset 0x8 loads the command byte onto cmd_o. A write to offset 0x9 sets (bit 2 = 1) or clears (bit 2 = 0) the software request of the channel named in bits 1:0. A read of any offset from 0x9 to 0xF returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational, zero when no read is active |
| dreq_i | input | 4 | Hardware request lines, reported in status |
| xfer_stb | input | 1 | One transfer completed |
| xfer_ch | input | 2 | Channel of the completed transfer |
| tc_o | output | 4 | Terminal-count pulse per channel |
| mask_o | output | 4 | Per-channel mask bits |
| mode_o | output | 32 | Mode bytes, channel n in bits 8n+7:8n |
| cmd_o | output | 8 | Command byte |

## Verification
The assertions watch, on every cycle, the events that take effect one edge later:
- the pointer toggling on a channel access, and its forced clear;
- the effect of master clear and of a single-mask write;
- a terminal-count pulse landing in the status flags, and never appearing on a masked channel;
- a status read emptying the flags.

Other behaviours show up only across whole host sequences, so the bench scenarios cover them:
- the order in which bytes come back through the shared pointer;
- the minus-one count encoding and the wrap to 0xFFFF;
- the auto-initialize reload;
- masked strobes leaving the registers untouched.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
  localparam logic [3:0] OFF_CMD     = 4'h8;
  localparam logic [3:0] OFF_REQ     = 4'h9;
  localparam logic [3:0] OFF_MASK1   = 4'hA;
  localparam logic [3:0] OFF_MODE    = 4'hB;
  localparam logic [3:0] OFF_CLRPTR  = 4'hC;
  localparam logic [3:0] OFF_MCLR    = 4'hD;
  localparam logic [3:0] OFF_CLRMASK = 4'hE;
  localparam logic [3:0] OFF_MASKALL = 4'hF;
  localparam int         AUTOINIT_BIT = 4;

  // address moves up by one per transfer
  function automatic logic [15:0] addr_step(input logic [15:0] a);
    return a + 16'd1;
  endfunction

  // count moves down by one; zero wraps to all ones
  function automatic logic [15:0] cnt_step(input logic [15:0] c);
    return c - 16'd1;
  endfunction

  function automatic logic cnt_done(input logic [15:0] c);
    return c == 16'd0;
  endfunction
endpackage

// File: rtl/xcr_byteptr.sv
module xcr_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic toggle,
  output logic hi
);
  always_ff @(posedge clk) begin
    if (!rst_n)      hi <= 1'b0;
    else if (clear)  hi <= 1'b0;
    else if (toggle) hi <= ~hi;
  end
endmodule

// File: rtl/xcr_chan.sv
module xcr_chan #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ld_addr,
  input  logic [1:0]      ld_cnt,
  input  logic [DW-1:0]   wdata,
  input  logic            mode_we,
  input  logic [DW-1:0]   mode_d,
  input  logic            step,
  output logic [2*DW-1:0] cur_addr,
  output logic [2*DW-1:0] cur_cnt,
  output logic [DW-1:0]   mode,
  output logic            tc_hit
);
  import xcr_pkg::*;
  localparam int RW = 2 * DW;

  logic [RW-1:0] base_addr, base_cnt;
  logic          host_load;

  assign host_load = (|ld_addr) | (|ld_cnt);
  assign tc_hit    = step & ~host_load & cnt_done(cur_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else if (host_load) begin
      if (ld_addr[0]) begin
        base_addr[DW-1:0] <= wdata;
        cur_addr[DW-1:0]  <= wdata;
      end
      if (ld_addr[1]) begin
        base_addr[RW-1:DW] <= wdata;
        cur_addr[RW-1:DW]  <= wdata;
      end
      if (ld_cnt[0]) begin
        base_cnt[DW-1:0] <= wdata;
        cur_cnt[DW-1:0]  <= wdata;
      end
      if (ld_cnt[1]) begin
        base_cnt[RW-1:DW] <= wdata;
        cur_cnt[RW-1:DW]  <= wdata;
      end
    end else if (step) begin
      if (tc_hit && mode[AUTOINIT_BIT]) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= addr_step(cur_addr);
        cur_cnt  <= cnt_step(cur_cnt);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mode <= '0;
    else if (mode_we) mode <= mode_d;
  end
endmodule

// File: rtl/xfer_ctl_regs.sv
module xfer_ctl_regs #(
  parameter int DW  = 8,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NCH-1:0]       dreq_i,
  input  logic                 xfer_stb,
  input  logic [$clog2(NCH)-1:0] xfer_ch,
  output logic [NCH-1:0]       tc_o,
  output logic [NCH-1:0]       mask_o,
  output logic [NCH*DW-1:0]    mode_o,
  output logic [DW-1:0]        cmd_o
);
  import xcr_pkg::*;
  localparam int CHW = $clog2(NCH);
  localparam int RW  = 2 * DW;

  logic           chan_port, sel_cnt, chan_acc, ptr_hi, status_rd, mclr;
  logic [CHW-1:0] sel_ch, wch;
  logic [NCH-1:0] tc_flags, sw_req, tc_hit;
  logic [RW-1:0]  cur_addr_a [NCH];
  logic [RW-1:0]  cur_cnt_a  [NCH];

  assign chan_port = ~bus_addr[3];
  assign sel_ch    = bus_addr[CHW:1];
  assign sel_cnt   = bus_addr[0];
  assign chan_acc  = (bus_wr | bus_rd) & chan_port;
  assign status_rd = bus_rd & (bus_addr == OFF_CMD);
  assign mclr      = bus_wr & (bus_addr == OFF_MCLR);
  assign wch       = bus_wdata[CHW-1:0];
  assign tc_o      = tc_hit;

  xcr_byteptr ptr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (mclr | (bus_wr & (bus_addr == OFF_CLRPTR))),
    .toggle (chan_acc),
    .hi     (ptr_hi)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_w;
    assign sel_w = bus_wr & chan_port & (sel_ch == CHW'(i));
    xcr_chan #(.DW(DW)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_addr  ({2{sel_w & ~sel_cnt}} & {ptr_hi, ~ptr_hi}),
      .ld_cnt   ({2{sel_w &  sel_cnt}} & {ptr_hi, ~ptr_hi}),
      .wdata    (bus_wdata),
      .mode_we  (bus_wr & (bus_addr == OFF_MODE) & (wch == CHW'(i))),
      .mode_d   (bus_wdata),
      .step     (xfer_stb & (xfer_ch == CHW'(i)) & ~mask_o[i]),
      .cur_addr (cur_addr_a[i]),
      .cur_cnt  (cur_cnt_a[i]),
      .mode     (mode_o[i*DW +: DW]),
      .tc_hit   (tc_hit[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mclr) begin
      mask_o <= '1;
    end else if (bus_wr) begin
      case (bus_addr)
        OFF_CLRMASK: mask_o <= '0;
        OFF_MASKALL: mask_o <= bus_wdata[NCH-1:0];
        OFF_MASK1:   mask_o[wch] <= bus_wdata[CHW];
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mclr) begin
      sw_req <= '0;
      cmd_o  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFF_REQ) sw_req[wch] <= bus_wdata[CHW];
      if (bus_addr == OFF_CMD) cmd_o <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mclr) tc_flags <= '0;
    else                tc_flags <= tc_hit | (status_rd ? '0 : tc_flags);
  end

  always_comb begin
    logic [RW-1:0] word;
    word      = sel_cnt ? cur_cnt_a[sel_ch] : cur_addr_a[sel_ch];
    bus_rdata = '0;
    if (bus_rd) begin
      if (chan_port)     bus_rdata = ptr_hi ? word[RW-1:DW] : word[DW-1:0];
      else if (status_rd) bus_rdata = {dreq_i | sw_req, tc_flags};
    end
  end
endmodule

// File: rtl/xcr_chk.sv
module xcr_chk #(
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [3:0]             bus_addr,
  input logic [7:0]             bus_wdata,
  input logic                   bus_wr,
  input logic                   chan_acc,
  input logic                   ptr_hi,
  input logic                   status_rd,
  input logic [NCH-1:0]         tc_o,
  input logic [NCH-1:0]         tc_flags,
  input logic [NCH-1:0]         mask_o
);
  a_r2_ptr_flip: assert property (@(posedge clk) disable iff (!rst_n)
    chan_acc |=> ptr_hi != $past(ptr_hi));

  a_r3_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'hC) |=> !ptr_hi);

  a_r5_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'hA) |=> mask_o[$past(bus_wdata[1:0])] == $past(bus_wdata[2]));

  a_r7_no_tc_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o & mask_o) == '0);

  a_r8_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'hD) |=> (mask_o == '1 && !ptr_hi && tc_flags == '0));

  a_r10_flag_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tc_o) && !(bus_wr && bus_addr == 4'hD)) |=> (tc_flags & $past(tc_o)) == $past(tc_o));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && tc_o == '0) |=> tc_flags == '0);
endmodule

bind xfer_ctl_regs xcr_chk #(.NCH(NCH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .chan_acc  (chan_acc),
  .ptr_hi    (ptr_hi),
  .status_rd (status_rd),
  .tc_o      (tc_o),
  .tc_flags  (tc_flags),
  .mask_o    (mask_o)
);

// File: tb/xfer_ctl_regs_tb_top.sv
module xfer_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [3:0]  dreq_i = '0;
  logic        xfer_stb = 1'b0;
  logic [1:0]  xfer_ch = '0;
  logic [3:0]  tc_o, mask_o;
  logic [31:0] mode_o;
  logic [7:0]  cmd_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xfer_ctl_regs dut_i (.*);

  // reference state
  logic [15:0] m_ba [4], m_ca [4], m_bc [4], m_cc [4];
  logic [7:0]  m_mode [4];
  logic [3:0]  m_mask, m_tc, m_sw;
  logic [7:0]  m_cmd;
  logic        m_ptr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_mode();
    return {m_mode[3], m_mode[2], m_mode[1], m_mode[0]};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    logic [15:0] w;
    if (a < 4'h8) begin
      w = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (a == 4'h8) return {dreq_i | m_sw, m_tc};
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
    end
    m_mask = 4'hF; m_tc = 0; m_sw = 0; m_cmd = 0; m_ptr = 0;
  endtask

  task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
    if (a < 4'h8) begin
      int c = a[2:1];
      if (a[0]) begin
        if (m_ptr) begin m_bc[c][15:8] = d; m_cc[c][15:8] = d; end
        else       begin m_bc[c][7:0]  = d; m_cc[c][7:0]  = d; end
      end else begin
        if (m_ptr) begin m_ba[c][15:8] = d; m_ca[c][15:8] = d; end
        else       begin m_ba[c][7:0]  = d; m_ca[c][7:0]  = d; end
      end
      m_ptr = ~m_ptr;
    end else case (a)
      4'h8: m_cmd = d;
      4'h9: m_sw[d[1:0]] = d[2];
      4'hA: m_mask[d[1:0]] = d[2];
      4'hB: m_mode[d[1:0]] = d;
      4'hC: m_ptr = 0;
      4'hD: begin m_ptr = 0; m_tc = 0; m_sw = 0; m_cmd = 0; m_mask = 4'hF; end
      4'hE: m_mask = 0;
      default: m_mask = d[3:0];
    endcase
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
    model_wr(a, d);
    chk(mask_o == m_mask, "R5/R9 mask_o", mask_o, m_mask);
    chk(mode_o == exp_mode(), "R6 mode_o", mode_o, exp_mode());
    chk(cmd_o == m_cmd, "R12 cmd_o", cmd_o, m_cmd);
  endtask

  task automatic do_rd(input logic [3:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 e = exp_rd(a);
    chk(bus_rdata == e, tag, bus_rdata, e);
    @(posedge clk); #1 bus_rd = 0;
    if (a < 4'h8) m_ptr = ~m_ptr;
    if (a == 4'h8) m_tc = 0;
  endtask

  task automatic do_xfer(input int c);
    logic [3:0] e;
    @(negedge clk);
    xfer_stb = 1; xfer_ch = 2'(c);
    e = (!m_mask[c] && m_cc[c] == 0) ? 4'(1 << c) : 4'h0;
    #1 chk(tc_o == e, "R7 tc_o pulse", tc_o, e);
    @(posedge clk); #1 xfer_stb = 0;
    if (!m_mask[c]) begin
      if (m_cc[c] == 0) begin
        m_tc[c] = 1;
        if (m_mode[c][4]) begin m_ca[c] = m_ba[c]; m_cc[c] = m_bc[c]; end
        else begin m_ca[c] = m_ca[c] + 1; m_cc[c] = 16'hFFFF; end
      end else begin
        m_ca[c] = m_ca[c] + 1; m_cc[c] = m_cc[c] - 1;
      end
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk(mask_o == 4'hF, "R1 masks", mask_o, 4'hF);
    chk(mode_o == 0 && cmd_o == 0, "R1 mode/cmd", {mode_o[23:0], cmd_o}, 0);
    do_rd(4'h8, "R1 status zero");
    do_rd(4'h0, "R1 ptr low first");
    do_wr(4'hC, 8'h5A);

    // R2/R4: byte order, minus-one count with 0 -> single transfer
    do_wr(4'h2, 8'h34); do_wr(4'h2, 8'h12);
    do_wr(4'h3, 8'h00); do_wr(4'h3, 8'h00);
    do_rd(4'h2, "R2 addr low byte");
    do_rd(4'h2, "R2 addr high byte");
    do_wr(4'hA, 8'h01);
    do_xfer(1);
    do_rd(4'h3, "R7 count wraps to FFFF lo");
    do_rd(4'h3, "R7 count wraps to FFFF hi");
    do_rd(4'h2, "R7 addr incremented");
    do_wr(4'hC, 0);
    do_rd(4'h8, "R10 status has tc and clears");
    do_rd(4'h8, "R10 status cleared");

    // R11 auto-initialize with count 1 -> two transfers
    do_wr(4'hB, 8'h56);
    do_wr(4'h4, 8'hF0); do_wr(4'h4, 8'h0F);
    do_wr(4'h5, 8'h01); do_wr(4'h5, 8'h00);
    do_wr(4'hA, 8'h02);
    do_xfer(2); do_xfer(2);
    do_rd(4'h4, "R11 reload addr lo"); do_rd(4'h4, "R11 reload addr hi");
    do_rd(4'h5, "R11 reload cnt lo");  do_rd(4'h5, "R11 reload cnt hi");

    // R7 masked strobe ignored; R9 mask-all and clear-mask
    do_wr(4'hF, 8'h08);
    do_xfer(3); do_xfer(3);
    do_rd(4'h6, "R7 masked addr unchanged lo"); do_rd(4'h6, "R7 masked addr unchanged hi");
    do_wr(4'hE, 8'h00);
    do_wr(4'hA, 8'h07);

    // R12 command, request, zero reads
    do_wr(4'h8, 8'hA5);
    do_wr(4'h9, 8'h06);
    dreq_i = 4'h1;
    do_rd(4'h8, "R12 sw request in status");
    do_rd(4'hD, "R12 temp reads zero");
    do_rd(4'hB, "R12 control offset reads zero");

    // R8 master clear after some state
    do_xfer(0);
    do_wr(4'h1, 8'h00);
    do_wr(4'hD, 8'h00);
    do_rd(4'h8, "R8 status cleared");
    do_rd(4'h0, "R8 ptr low");

    // R4 full count 0xFFFF: 65536 transfers to terminal count
    do_wr(4'hC, 0);
    do_wr(4'h1, 8'hFF); do_wr(4'h1, 8'hFF);
    do_wr(4'hA, 8'h00);
    for (int k = 0; k < 65535; k++) begin
      @(negedge clk); xfer_stb = 1; xfer_ch = 0;
      @(posedge clk); #1 xfer_stb = 0;
      m_ca[0] = m_ca[0] + 1; m_cc[0] = m_cc[0] - 1;
    end
    do_xfer(0);
    do_rd(4'h8, "R4 tc after 65536 transfers");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int op = $urandom_range(0, 11);
      logic [3:0] a;
      logic [7:0] d;
      d = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(0, 2)) : 8'($urandom);
      dreq_i = 4'($urandom);
      case (op)
        0, 1, 2: do_wr(4'($urandom_range(0, 7)), d);
        3:       do_wr(4'hC, d);
        4:       do_wr(4'hA, 8'($urandom_range(0, 7)));
        5:       do_wr(4'hB, {($urandom_range(0,1) != 0) ? 4'h5 : 4'h4, 4'($urandom_range(0,3))});
        6, 7:    do_xfer($urandom_range(0, 3));
        8, 9: begin
          a = 4'($urandom_range(0, 7));
          do_rd(a, "R2 random channel read");
        end
        10:      do_rd(4'h8, "R10 random status");
        default: begin
          a = 4'($urandom_range(9, 15));
          if (a == 4'hD && $urandom_range(0, 7) != 0) a = 4'hE;
          do_wr(a, d);
        end
      endcase
    end
    summary();
  end
endmodule